// File: doc/BRIEF.md
# Inline Header Packet Packer

This block builds an outgoing packet stream in which each packet's header and its payload share one data bus. A header descriptor gives up to eight header dwords, the number of dwords in use, and the payload length in bytes. The payload itself arrives as a separate stream of full-width beats. The block places the header in a fixed 32-byte slot at byte 0 of a fresh output beat. Within each header dword it swaps the bytes so the most significant byte comes first. Dwords beyond the count in use are zero-filled.

Payload bytes keep their little-endian dword order and follow directly after the 32-byte slot. On a 512-bit bus the first payload bytes share the header beat, so every later payload beat is shifted by 32 bytes. On 256-bit and 128-bit buses the header fills one or two whole beats, and the payload follows without any shift.

The output is an AXI4-Stream master with data, byte-keep, last, valid and ready. The descriptor and payload inputs use valid/ready handshakes that stall independently of each other. A new descriptor is taken only once the previous packet's final beat leaves the block.

Top module: `inline_hdr_packer`

## Requirements
- R1: The first 32 bytes of each packet carry the header: dword i sits at packet bytes 4i..4i+3, with its bits [31:24] at byte 4i and its bits [7:0] at byte 4i+3. Dwords with index at or above `hdrDwCnt` are sent as zero.
- R2: Payload byte j is sent at packet byte 32+j. Payload byte j is taken from byte (j mod BYTES) of input payload beat (j div BYTES), where BYTES = DATA_W/8 and byte k of a beat is data bits [8k+7:8k].
- R3: Each packet starts at byte 0 of a new output beat and occupies exactly ceil((32+len)/BYTES) beats. Packets leave in descriptor order.
- R4: With DATA_W = 128, the header takes two consecutive output beats. The second is presented only after the first has been accepted.
- R5: `txKeep` bit k is high exactly for the valid bytes of a beat: every non-final beat is all ones, and the final beat has the low ((32+len-1) mod BYTES)+1 bits set. Data bytes whose keep bit is low are zero.
- R6: `txLast` is high on the final beat of each packet only. This includes a packet with zero payload, whose last header beat carries it.
- R7: `hdrReady` is high only when no packet is in progress and the output holds no beat, or when the held final beat is transferred at the same edge.
- R8: Exactly ceil(len/BYTES) payload beats are consumed per packet, and `plReady` stays low when the active packet needs no more input.
- R9: While `txValid` is high and `txReady` is low, `txValid`, `txData`, `txKeep` and `txLast` hold their values at the next clock.
- R10: A synchronous active-high `rst` drops `txValid` at the next edge, discards any packet in progress, and leaves `hdrReady` high while `txReady` is high.
- R11: `DATA_W` selects a bus of 128, 256 or 512 bits, and every rule above holds for each width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdrValid | input | 1 | Descriptor valid |
| hdrReady | output | 1 | Descriptor accepted at this edge when valid |
| hdrWords | input | 256 | Header dwords, dword i at bits [32i+31:32i] |
| hdrDwCnt | input | 4 | Number of header dwords in use (1..8) |
| hdrLen | input | LEN_W | Payload length in bytes |
| plValid | input | 1 | Payload beat valid |
| plReady | output | 1 | Payload beat consumed at this edge when valid |
| plData | input | DATA_W | Payload beat, little-endian bytes |
| txData | output | DATA_W | Output stream data |
| txKeep | output | DATA_W/8 | Output byte-valid mask |
| txLast | output | 1 | Final beat of a packet |
| txValid | output | 1 | Output beat valid |
| txReady | input | 1 | Downstream ready |

## Verification
The assertions assume a few things about the inputs. `hdrDwCnt` lies in 1..8. The payload stream supplies exactly ceil(len/BYTES) beats per packet, in descriptor order. The bytes of a final input beat past the length are don't-care. The stimulus is built to stay within these limits. Each packet's payload beats are generated from its own length. The spare bytes of a final input beat are filled with random garbage, so the zeroing of unkept bytes is tested. Descriptor valid, payload valid and downstream ready are toggled at random, and descriptor and payload handshakes are never coupled, so the checks cover payload that arrives before or after its descriptor.

// File: rtl/pkr_pkg.sv
package pkr_pkg;
  localparam int HDR_SLOT_BYTES = 32;
  localparam int HDR_SLOT_DW    = 8;

  // Strobes from the sequencer to the datapath for one output beat.
  typedef struct packed {
    logic       capture;   // latch a new descriptor
    logic       emitHdr;   // load a pure header beat
    logic       emitPay;   // load a payload (or mixed) beat
    logic       takeIn;    // the payload beat on plData is consumed
    logic [1:0] hdrIdx;    // which header beat
    logic [6:0] nBytes;    // valid bytes in the beat
    logic       last;      // final beat of the packet
  } pkr_strobe_t;
endpackage

// File: rtl/pkr_ctrl.sv
module pkr_ctrl
  import pkr_pkg::*;
#(
  parameter int DATA_W = 512,
  parameter int LEN_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hdrValid,
  output logic             hdrReady,
  input  logic [LEN_W-1:0] hdrLen,
  input  logic             plValid,
  output logic             plReady,
  input  logic             outValid,
  input  logic             outReady,
  input  logic             outLast,
  output pkr_strobe_t      strb
);
  localparam int BYTES     = DATA_W / 8;
  localparam int HDR_BEATS = HDR_SLOT_BYTES / BYTES;
  localparam int CW        = LEN_W + 1;
  localparam logic [CW-1:0]    BYTES_C   = CW'(BYTES);
  localparam logic [LEN_W-1:0] BYTES_L   = LEN_W'(BYTES);
  localparam logic [1:0]       LAST_HIDX = 2'((HDR_BEATS > 0) ? HDR_BEATS - 1 : 0);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY} state_t;

  state_t           state;
  logic [CW-1:0]    outLeft;
  logic [LEN_W-1:0] inLeft;
  logic [1:0]       hIdx;
  logic             lenZero;
  logic             canLoad;
  logic             needIn;
  logic [6:0]       beatBytes;

  always_comb begin
    canLoad   = !outValid || outReady;
    needIn    = (inLeft != '0);
    hdrReady  = (state == S_IDLE) && canLoad;
    plReady   = (state == S_PAY) && canLoad && needIn;
    beatBytes = (outLeft >= BYTES_C) ? 7'(BYTES) : outLeft[6:0];
    strb      = '0;
    strb.capture = hdrValid && hdrReady;
    case (state)
      S_HDR: begin
        strb.emitHdr = canLoad;
        strb.hdrIdx  = hIdx;
        strb.nBytes  = 7'(BYTES);
        strb.last    = lenZero && (hIdx == LAST_HIDX);
      end
      S_PAY: begin
        strb.emitPay = canLoad && (!needIn || plValid);
        strb.takeIn  = canLoad && needIn && plValid;
        strb.nBytes  = beatBytes;
        strb.last    = (outLeft <= BYTES_C);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      outLeft <= '0;
      inLeft  <= '0;
      hIdx    <= '0;
      lenZero <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (strb.capture) begin
          outLeft <= CW'(HDR_SLOT_BYTES) + CW'(hdrLen);
          inLeft  <= hdrLen;
          lenZero <= (hdrLen == '0);
          hIdx    <= '0;
          state   <= (HDR_BEATS > 0) ? S_HDR : S_PAY;
        end
        S_HDR: if (strb.emitHdr) begin
          hIdx    <= hIdx + 2'd1;
          outLeft <= outLeft - BYTES_C;
          if (hIdx == LAST_HIDX) state <= lenZero ? S_IDLE : S_PAY;
        end
        S_PAY: if (strb.emitPay) begin
          outLeft <= outLeft - CW'(beatBytes);
          inLeft  <= (inLeft > BYTES_L) ? inLeft - BYTES_L : '0;
          if (strb.last) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  accept_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (hdrValid && hdrReady) |-> (!outValid || (outReady && outLast)));
endmodule

// File: rtl/pkr_dpath.sv
module pkr_dpath
  import pkr_pkg::*;
#(
  parameter int DATA_W = 512
) (
  input  logic                  clk,
  input  logic                  rst,
  input  pkr_strobe_t           strb,
  input  logic [255:0]          hdrWords,
  input  logic [3:0]            hdrDwCnt,
  input  logic [DATA_W-1:0]     plData,
  input  logic                  outReady,
  output logic [DATA_W-1:0]     outData,
  output logic [DATA_W/8-1:0]   outKeep,
  output logic                  outLast,
  output logic                  outValid
);
  localparam int BYTES   = DATA_W / 8;
  localparam int SHIFT_B = HDR_SLOT_BYTES % BYTES;
  localparam int SLOT_W  = HDR_SLOT_BYTES * 8;

  logic [SLOT_W-1:0] slotReg;
  logic [DATA_W-1:0] hdrBeat;
  logic [DATA_W-1:0] payBeat;
  logic [BYTES-1:0]  beatKeep;
  logic [DATA_W-1:0] beatMask;

  function automatic logic [SLOT_W-1:0] swapHdr(input logic [SLOT_W-1:0] w,
                                                 input logic [3:0] cnt);
    logic [SLOT_W-1:0] r;
    logic [31:0] d;
    for (int i = 0; i < HDR_SLOT_DW; i++) begin
      d = w[32*i +: 32];
      r[32*i +: 32] = (i < int'(cnt)) ? {d[7:0], d[15:8], d[23:16], d[31:24]} : 32'h0;
    end
    return r;
  endfunction

  always_comb begin
    hdrBeat = DATA_W'(slotReg >> (DATA_W * int'(strb.hdrIdx)));
    for (int i = 0; i < BYTES; i++) begin
      beatKeep[i]       = (i < int'(strb.nBytes));
      beatMask[8*i +: 8] = {8{beatKeep[i]}};
    end
  end

  generate
    if (SHIFT_B == 0) begin : gAligned
      // Header fills whole beats; payload beats pass straight through.
      always_ff @(posedge clk) begin
        if (rst)               slotReg <= '0;
        else if (strb.capture) slotReg <= swapHdr(hdrWords, hdrDwCnt);
      end
      always_comb payBeat = strb.takeIn ? plData : '0;
    end else begin : gShifted
      // Slot register starts as the header, then carries the top of each input beat.
      localparam int LOW_W = DATA_W - SLOT_W;
      logic [LOW_W-1:0] lowIn;
      always_ff @(posedge clk) begin
        if (rst)                              slotReg <= '0;
        else if (strb.capture)                slotReg <= swapHdr(hdrWords, hdrDwCnt);
        else if (strb.emitPay && strb.takeIn) slotReg <= plData[DATA_W-1 -: SLOT_W];
      end
      always_comb begin
        lowIn   = strb.takeIn ? plData[LOW_W-1:0] : '0;
        payBeat = {lowIn, slotReg};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData  <= '0;
      outKeep  <= '0;
      outLast  <= 1'b0;
    end else if (strb.emitHdr || strb.emitPay) begin
      outValid <= 1'b1;
      outData  <= (strb.emitHdr ? hdrBeat : payBeat) & beatMask;
      outKeep  <= beatKeep;
      outLast  <= strb.last;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outKeep) && $stable(outLast)));
  // R5
  keep_contig_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ((outKeep != '0) && ((outKeep & (outKeep + 1'b1)) == '0)));
  // R5
  keep_full_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outLast) |-> (&outKeep));
  // R10
  reset_clear_chk: assert property (@(posedge clk) rst |=> !outValid);
endmodule

// File: rtl/inline_hdr_packer.sv
module inline_hdr_packer
  import pkr_pkg::*;
#(
  parameter int DATA_W = 512,
  parameter int LEN_W  = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hdrValid,
  output logic                hdrReady,
  input  logic [255:0]        hdrWords,
  input  logic [3:0]          hdrDwCnt,
  input  logic [LEN_W-1:0]    hdrLen,
  input  logic                plValid,
  output logic                plReady,
  input  logic [DATA_W-1:0]   plData,
  output logic [DATA_W-1:0]   txData,
  output logic [DATA_W/8-1:0] txKeep,
  output logic                txLast,
  output logic                txValid,
  input  logic                txReady
);
  // R11
  if (!(DATA_W == 128 || DATA_W == 256 || DATA_W == 512)) begin : gBadWidth
    $error("inline_hdr_packer: DATA_W must be 128, 256 or 512");
  end

  pkr_strobe_t strb;

  pkr_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rst(rst),
    .hdrValid(hdrValid), .hdrReady(hdrReady), .hdrLen(hdrLen),
    .plValid(plValid), .plReady(plReady),
    .outValid(txValid), .outReady(txReady), .outLast(txLast),
    .strb(strb)
  );

  pkr_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rst(rst), .strb(strb),
    .hdrWords(hdrWords), .hdrDwCnt(hdrDwCnt), .plData(plData),
    .outReady(txReady), .outData(txData), .outKeep(txKeep),
    .outLast(txLast), .outValid(txValid)
  );
endmodule

// File: tb/sim_inline_hdr_packer.sv
module pkr_harness #(
  parameter int W    = 512,
  parameter int SEED = 1
) (
  input  logic clk,
  input  logic rst,
  output logic done,
  output int   checks,
  output int   errors
);
  localparam int B    = W / 8;
  localparam int NPKT = 14;

  logic          hdrValid, hdrReady, plValid, plReady, txLast, txValid, txReady;
  logic [255:0]  hdrWords;
  logic [3:0]    hdrDwCnt;
  logic [11:0]   hdrLen;
  logic [W-1:0]  plData, txData;
  logic [B-1:0]  txKeep;

  inline_hdr_packer #(.DATA_W(W), .LEN_W(12)) u0 (
    .clk(clk), .rst(rst), .hdrValid(hdrValid), .hdrReady(hdrReady),
    .hdrWords(hdrWords), .hdrDwCnt(hdrDwCnt), .hdrLen(hdrLen),
    .plValid(plValid), .plReady(plReady), .plData(plData),
    .txData(txData), .txKeep(txKeep), .txLast(txLast),
    .txValid(txValid), .txReady(txReady)
  );

  logic [W-1:0] plQ[$];
  logic [W-1:0] expD[$];
  logic [B-1:0] expK[$];
  bit           expL[$];
  bit           expH[$];

  int pktIdx, plAllowed, plConsumed, rstNeg;
  bit hdrTaken, plTaken, prevHold;
  logic [W-1:0] prevD;
  logic [B-1:0] prevK;
  logic         prevL;

  function automatic int lenOf(input int p);
    case (p)
      0: return 0;    1: return 1;    2: return 4;    3: return 15;
      4: return 16;   5: return 31;   6: return 32;   7: return 33;
      8: return 63;   9: return 64;   10: return 65;  11: return 100;
      12: return 191; default: return 300;
    endcase
  endfunction

  function automatic logic [31:0] hword(input int p, input int i);
    return {8'(p * 17 + i), 8'(i * 29 + 3), 8'(p + i * 5 + SEED), 8'(8'h40 + i)};
  endfunction

  function automatic logic [7:0] pbyte(input int p, input int j);
    return 8'((p * 37 + j * 13 + SEED) ^ (j >> 3));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (W=%0d): actual %h expected %h", tag, W, act, exp);
    end
  endtask

  task automatic pushExp(input int p);
    logic [7:0] bs[$];
    logic [31:0] w;
    int nb;
    logic [W-1:0] d;
    logic [B-1:0] k;
    for (int i = 0; i < 8; i++) begin
      w = (i < (p % 8) + 1) ? hword(p, i) : 32'h0;
      bs.push_back(w[31:24]); bs.push_back(w[23:16]);
      bs.push_back(w[15:8]);  bs.push_back(w[7:0]);
    end
    for (int j = 0; j < lenOf(p); j++) bs.push_back(pbyte(p, j));
    nb = (bs.size() + B - 1) / B;
    for (int b = 0; b < nb; b++) begin
      d = '0; k = '0;
      for (int x = 0; x < B; x++) begin
        if (b * B + x < bs.size()) begin
          d[8*x +: 8] = bs[b * B + x];
          k[x] = 1'b1;
        end
      end
      expD.push_back(d); expK.push_back(k);
      expL.push_back(b == nb - 1); expH.push_back(b * B < 32);
    end
  endtask

  initial begin
    logic [W-1:0] beat;
    int nb;
    checks = 0; errors = 0; done = 1'b0;
    pktIdx = 0; plAllowed = 0; plConsumed = 0; rstNeg = 0;
    hdrTaken = 0; plTaken = 0; prevHold = 0;
    hdrValid = 0; plValid = 0; txReady = 1; hdrWords = '0; hdrDwCnt = 4'd1;
    hdrLen = '0; plData = '0;
    for (int p = 0; p < NPKT; p++) begin
      nb = (lenOf(p) + B - 1) / B;
      for (int b = 0; b < nb; b++) begin
        for (int x = 0; x < B; x++)
          beat[8*x +: 8] = (b * B + x < lenOf(p)) ? pbyte(p, b * B + x) : 8'($urandom);
        plQ.push_back(beat);
      end
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      hdrValid = 0; plValid = 0; txReady = 1;
      rstNeg++;
      if (rstNeg == 3) begin
        // R10: output idle and descriptor port open while in reset
        chk(!txValid, "R10 txValid", W'(txValid), '0);
        chk(hdrReady, "R10 hdrReady", W'(hdrReady), W'(1));
      end
    end else if (!done) begin
      if (hdrTaken) pktIdx++;
      hdrTaken = 0;
      if (plTaken) void'(plQ.pop_front());
      plTaken = 0;
      hdrValid = (pktIdx < NPKT) && ($urandom % 4 != 0);
      if (pktIdx < NPKT) begin
        for (int i = 0; i < 8; i++) hdrWords[32*i +: 32] = hword(pktIdx, i);
        hdrDwCnt = 4'((pktIdx % 8) + 1);
        hdrLen   = 12'(lenOf(pktIdx));
      end
      plValid = (plQ.size() > 0) && ($urandom % 5 != 0);
      plData  = (plQ.size() > 0) ? plQ[0] : '0;
      txReady = (pktIdx < 4) ? 1'b1 : ($urandom % 3 != 0);
      #1;
      if (prevHold) begin
        // R9: a stalled beat must stay put
        chk(txValid && txData == prevD && txKeep == prevK && txLast == prevL,
            "R9 hold", txData, prevD);
      end
      if (txValid) begin
        if (expD.size() == 0) begin
          chk(0, "R3 unexpected beat", txData, '0);
        end else begin
          if (expH[0])
            chk(txData == expD[0], (W == 128) ? "R1 R4 header beat" : "R1 R2 header beat",
                txData, expD[0]);
          else
            chk(txData == expD[0], "R2 payload beat", txData, expD[0]);
          chk(txKeep == expK[0], "R5 keep", W'(txKeep), W'(expK[0]));
          chk(txLast == expL[0], "R6 last", W'(txLast), W'(expL[0]));
          if (txReady) begin
            void'(expD.pop_front()); void'(expK.pop_front());
            void'(expL.pop_front()); void'(expH.pop_front());
          end
        end
      end
      prevHold = txValid && !txReady;
      prevD = txData; prevK = txKeep; prevL = txLast;
      if (hdrValid && hdrReady) begin
        // R7: previous packet fully gone (or leaving now)
        chk(expD.size() == 0, "R7 early accept", W'(expD.size()), '0);
        pushExp(pktIdx);
        plAllowed += (lenOf(pktIdx) + B - 1) / B;
        hdrTaken = 1;
      end
      if (plValid && plReady) begin
        // R8: no payload beat beyond what accepted packets need
        chk(plConsumed < plAllowed, "R8 extra payload", W'(plConsumed), W'(plAllowed));
        plConsumed++;
        plTaken = 1;
      end
      if (pktIdx == NPKT && !hdrTaken && expD.size() == 0 && !txValid) begin
        chk(plConsumed == plAllowed && plQ.size() == 0 && plAllowed > 0,
            "R8 payload count", W'(plConsumed), W'(plAllowed));
        done = 1'b1;
      end
    end
  end
endmodule

module sim_inline_hdr_packer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic doneA, doneB, doneC;
  int   chkA, chkB, chkC, errA, errB, errC;
  int   cycles = 0;

  always #10 clk = ~clk;

  // R11: every supported width is exercised
  pkr_harness #(.W(512), .SEED(3)) hWide (.clk(clk), .rst(rst), .done(doneA), .checks(chkA), .errors(errA));
  pkr_harness #(.W(256), .SEED(5)) hMid  (.clk(clk), .rst(rst), .done(doneB), .checks(chkB), .errors(errB));
  pkr_harness #(.W(128), .SEED(7)) hNarrow (.clk(clk), .rst(rst), .done(doneC), .checks(chkC), .errors(errC));

  initial begin
    int wdErr;
    wdErr = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    while (!(doneA && doneB && doneC) && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!(doneA && doneB && doneC)) begin
      wdErr = 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    #5;
    $display("Simulation finished: %0d checks, %0d errors",
             chkA + chkB + chkC + wdErr, errA + errB + errC + wdErr);
    $finish;
  end
endmodule